// File: doc/BRIEF.md
# VSync Phase-Error Frame Tracker

This block sits in the fixed reference-clock domain of a video output path and judges how far the locally generated output vertical sync is from an external master vertical sync. Each frame it counts reference cycles from the master sync rising edge to the output sync rising edge. It subtracts a programmable tracking offset from that count and folds the result into a signed range of about half a frame. The result is an error that a downstream clock generator drives to zero by stretching or shrinking the output frame period.

Each error comes with a one-cycle valid strobe. A request to shorten or lengthen the output period goes with it when the error is outside a small window, and a lock flag summarises recent history. The offset lets the output be deliberately delayed against the master. A value of zero makes the two edges coincide, and each step adds one reference cycle of delay. The error sign convention is: positive means the output edge is late (shorten the output period), negative means it is early (lengthen it).

Top module: `vsync_phase_tracker`

## Requirements
- R1: Both sync inputs pass through a two-stage synchronizer, and only their rising edges count. The phase of a frame is the number of reference cycles from a master rising edge to the first output rising edge that follows it, and it is 0 when the two edges fall in the same cycle.
- R2: The reported error is phase minus offset, with P the length of the frame that just ended. When this difference is at least floor(P/2), P is subtracted. When it is below floor(P/2)-P, P is added. The error therefore lies in [floor(P/2)-P, floor(P/2)-1]. The offset must be less than P.
- R3: P is the number of reference cycles between the two master rising edges that bound the frame, measured anew every frame.
- R4: `err_valid` is a one-cycle pulse issued a few cycles after each master rising edge, and it reports the frame that edge ends. There is no pulse for a frame without an output edge, and none for the first master edge after enable or after a missing-master event.
- R5: With `err_valid`, `adj_shorten` is high when the error is greater than +2 and `adj_lengthen` is high when the error is less than -2. Neither is high for an error in [-2, +2], and neither is high without `err_valid`.
- R6: `locked` rises together with the fourth consecutive in-window error (|error| <= 2).
- R7: `locked` falls with the second consecutive out-of-window error. A single out-of-window error followed by an in-window one leaves it set.
- R8: If no master rising edge arrives for more than twice the last measured period, `locked` clears and the measurement restarts as after enable.
- R9: While `en` is low, the counters, lock flag and adjust requests are held clear, and no `err_valid` is issued.
- R10: After reset, `err`, `err_valid`, `adj_shorten`, `adj_lengthen` and `locked` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Tracker enable; low clears all state |
| master_vs | input | 1 | External master vertical sync (asynchronous) |
| out_vs | input | 1 | Local output vertical sync (asynchronous) |
| track_ofs | input | OFS_W | Tracking offset in reference cycles of output delay |
| err | output | CNT_W+2 | Signed wrapped phase error, two's complement |
| err_valid | output | 1 | One-cycle strobe, one per master frame |
| adj_shorten | output | 1 | Request to shorten the output period (output late) |
| adj_lengthen | output | 1 | Request to lengthen the output period (output early) |
| locked | output | 1 | Lock indication |

## Verification
The output edge is placed at distances that include coincident edges, one cycle on either side, and just below and at the half-period wrap point. Odd and even frame lengths are both used, so the wrap boundary shows whether the current period is used and whether floor rounding is applied. Non-zero offsets, including one close to a full period, separate a plain subtraction from the folded result. Lock sequences tell the four-in-a-row entry apart from a premature one and a single stray frame apart from two in a row. Stopping the master and dropping the enable show whether the measurement restarts cleanly, with no stale error reported afterwards.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic {
    LK_HUNT = 1'b0,
    LK_HELD = 1'b1
  } lock_st_t;

  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/vpt_edge_sync.sv
module vpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // R1: a rising edge is reported for exactly one cycle
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vpt_phase_meas.sv
module vpt_phase_meas #(
  parameter int CNT_W = 22,
  parameter int OFS_W = 21,
  localparam int RAW_W = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    m_rise,
  input  logic                    o_rise,
  input  logic [OFS_W-1:0]        ofs_i,
  output logic signed [RAW_W-1:0] err_o,
  output logic                    err_vld_o,
  output logic                    lost_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] per_cnt_q, period_q, ph_cnt_q, ph_cap_q;
  logic             have_edge_q, per_ok_q, ph_run_q, ph_seen_q;

  logic signed [RAW_W-1:0] raw_s, per_s, half_s, wrap_s;
  logic                    silent_long;

  always_comb begin
    raw_s  = $signed({2'b00, ph_cap_q}) - $signed({{(RAW_W-OFS_W){1'b0}}, ofs_i});
    per_s  = $signed({2'b00, per_cnt_q});
    half_s = $signed({3'b000, per_cnt_q[CNT_W-1:1]});
    if (raw_s >= half_s)              wrap_s = raw_s - per_s;
    else if (raw_s < half_s - per_s)  wrap_s = raw_s + per_s;
    else                              wrap_s = raw_s;
  end

  assign silent_long = per_ok_q && ({1'b0, per_cnt_q} > {period_q, 1'b0});

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      per_cnt_q   <= '0;
      period_q    <= '0;
      ph_cnt_q    <= '0;
      ph_cap_q    <= '0;
      have_edge_q <= 1'b0;
      per_ok_q    <= 1'b0;
      ph_run_q    <= 1'b0;
      ph_seen_q   <= 1'b0;
      err_o       <= '0;
      err_vld_o   <= 1'b0;
      lost_o      <= 1'b0;
    end else begin
      err_vld_o <= 1'b0;
      lost_o    <= 1'b0;

      if (m_rise)                    per_cnt_q <= CNT_W'(1);
      else if (per_cnt_q != CNT_MAX) per_cnt_q <= per_cnt_q + 1'b1;

      if (m_rise) begin
        have_edge_q <= 1'b1;
        if (have_edge_q) begin
          period_q <= per_cnt_q;
          per_ok_q <= 1'b1;
          if (ph_seen_q) begin
            err_o     <= wrap_s;
            err_vld_o <= 1'b1;
          end
        end
        ph_cnt_q <= CNT_W'(1);
        if (o_rise) begin
          ph_cap_q  <= '0;
          ph_seen_q <= 1'b1;
          ph_run_q  <= 1'b0;
        end else begin
          ph_seen_q <= 1'b0;
          ph_run_q  <= 1'b1;
        end
      end else if (silent_long) begin
        lost_o      <= 1'b1;
        have_edge_q <= 1'b0;
        per_ok_q    <= 1'b0;
        ph_run_q    <= 1'b0;
        ph_seen_q   <= 1'b0;
      end else if (ph_run_q) begin
        if (o_rise) begin
          ph_cap_q  <= ph_cnt_q;
          ph_seen_q <= 1'b1;
          ph_run_q  <= 1'b0;
        end else if (ph_cnt_q != CNT_MAX) begin
          ph_cnt_q <= ph_cnt_q + 1'b1;
        end
      end
    end
  end

  logic signed [RAW_W-1:0] chk_half, chk_per;
  always_comb begin
    chk_half = $signed({3'b000, period_q[CNT_W-1:1]});
    chk_per  = $signed({2'b00, period_q});
  end

  // R2: reported error stays inside the folded range of the frame it reports
  p_err_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    err_vld_o |-> (err_o < chk_half) && (err_o >= chk_half - chk_per));
  // R4: a result appears only right after a master edge
  p_valid_after_edge_r4: assert property (@(posedge clk) disable iff (rst)
    err_vld_o |-> $past(m_rise));
  // R8: a missing-master event never coincides with a master edge
  p_lost_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    lost_o |-> !$past(m_rise));
endmodule

// File: rtl/vpt_lock_track.sv
module vpt_lock_track
  import vpt_pkg::*;
#(
  parameter int ERR_W    = 24,
  parameter int WIN      = 2,
  parameter int LOCK_N   = 4,
  parameter int UNLOCK_N = 2,
  localparam int LC_W = $clog2(LOCK_N + 1),
  localparam int UC_W = $clog2(UNLOCK_N + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    vld_i,
  input  logic                    lost_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_vld_o,
  output logic                    adj_shorten_o,
  output logic                    adj_lengthen_o,
  output logic                    locked_o
);
  localparam logic signed [ERR_W-1:0] WIN_P = ERR_W'(WIN);
  localparam logic signed [ERR_W-1:0] WIN_N = -WIN_P;

  lock_st_t        st_q;
  logic [LC_W-1:0] in_run_q;
  logic [UC_W-1:0] out_run_q;
  logic            in_win;

  assign in_win = (err_i <= WIN_P) && (err_i >= WIN_N);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q           <= LK_HUNT;
      in_run_q       <= '0;
      out_run_q      <= '0;
      err_o          <= '0;
      err_vld_o      <= 1'b0;
      adj_shorten_o  <= 1'b0;
      adj_lengthen_o <= 1'b0;
    end else begin
      err_vld_o      <= 1'b0;
      adj_shorten_o  <= 1'b0;
      adj_lengthen_o <= 1'b0;
      if (lost_i) begin
        st_q      <= LK_HUNT;
        in_run_q  <= '0;
        out_run_q <= '0;
      end else if (vld_i) begin
        err_o          <= err_i;
        err_vld_o      <= 1'b1;
        adj_shorten_o  <= err_i > WIN_P;
        adj_lengthen_o <= err_i < WIN_N;
        if (in_win) begin
          out_run_q <= '0;
          if (in_run_q == LC_W'(LOCK_N - 1)) st_q <= LK_HELD;
          else                               in_run_q <= in_run_q + 1'b1;
        end else begin
          in_run_q <= '0;
          if (out_run_q == UC_W'(UNLOCK_N - 1)) st_q <= LK_HUNT;
          else                                  out_run_q <= out_run_q + 1'b1;
        end
      end
    end
  end

  assign locked_o = (st_q == LK_HELD);

  // R5: never both requests at once
  p_adj_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(adj_shorten_o && adj_lengthen_o));
  // R5: a request always travels with a reported error
  p_adj_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (adj_shorten_o || adj_lengthen_o) |-> err_vld_o);
  // R6: lock is gained only together with a reported error
  p_lock_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> err_vld_o);
  // R7: lock is lost only on an error, a missing master or disable
  p_unlock_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> (err_vld_o || $past(lost_i) || $past(!en)));
  // R8: missing master drops the lock
  p_lost_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
    lost_i |=> !locked_o);
  // R9: disabled tracker stays silent
  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!locked_o && !err_vld_o && !adj_shorten_o && !adj_lengthen_o));
endmodule

// File: rtl/vsync_phase_tracker.sv
module vsync_phase_tracker
  import vpt_pkg::*;
#(
  parameter int CNT_W       = 22,
  parameter int OFS_W       = 21,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int WIN         = 2,
  parameter int LOCK_N      = 4,
  parameter int UNLOCK_N    = 2,
  localparam int ERR_W      = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    master_vs,
  input  logic                    out_vs,
  input  logic [OFS_W-1:0]        track_ofs,
  output logic signed [ERR_W-1:0] err,
  output logic                    err_valid,
  output logic                    adj_shorten,
  output logic                    adj_lengthen,
  output logic                    locked
);
  localparam int CH_M = 0;
  localparam int CH_O = 1;

  logic [1:0]              vs_raw, vs_rise;
  logic signed [ERR_W-1:0] meas_err;
  logic                    meas_vld, meas_lost;

  assign vs_raw = {out_vs, master_vs};

  for (genvar ch = 0; ch < 2; ch++) begin : g_sync
    vpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (vs_raw[ch]),
      .rise_o  (vs_rise[ch])
    );
  end

  vpt_phase_meas #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_meas (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .m_rise    (vs_rise[CH_M]),
    .o_rise    (vs_rise[CH_O]),
    .ofs_i     (track_ofs),
    .err_o     (meas_err),
    .err_vld_o (meas_vld),
    .lost_o    (meas_lost)
  );

  vpt_lock_track #(
    .ERR_W(ERR_W), .WIN(WIN), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)
  ) u_lock (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .err_i          (meas_err),
    .vld_i          (meas_vld),
    .lost_i         (meas_lost),
    .err_o          (err),
    .err_vld_o      (err_valid),
    .adj_shorten_o  (adj_shorten),
    .adj_lengthen_o (adj_lengthen),
    .locked_o       (locked)
  );

  // R4: valid strobe is a single-cycle pulse
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> !err_valid);
endmodule

// File: tb/vsync_phase_tracker_tb_top.sv
module vsync_phase_tracker_tb_top;
  localparam int W = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en = 1'b0;
  logic               master_vs = 1'b0;
  logic               out_vs = 1'b0;
  logic [20:0]        track_ofs = '0;
  logic signed [23:0] err;
  logic               err_valid, adj_shorten, adj_lengthen, locked;

  vsync_phase_tracker dut_i (
    .clk(clk), .rst(rst), .en(en), .master_vs(master_vs), .out_vs(out_vs),
    .track_ofs(track_ofs), .err(err), .err_valid(err_valid),
    .adj_shorten(adj_shorten), .adj_lengthen(adj_lengthen), .locked(locked)
  );

  always #2.5 clk = ~clk;

  typedef struct { int e; bit sh; bit ln; } exp_t;
  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   prev_ok = 0;
  int   prev_d = 0, prev_p = 0;
  int   m_hold = 0, o_hold = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input int d, input int ofs, input int p);
    exp_t r;
    int raw, half;
    raw  = d - ofs;
    half = p / 2;
    if (raw >= half)          raw -= p;
    else if (raw < half - p)  raw += p;
    r.e  = raw;
    r.sh = raw > 2;
    r.ln = raw < -2;
    return r;
  endfunction

  task automatic drive_frame(input int p, input int d);
    if (prev_ok && en) q.push_back(model(prev_d, int'(track_ofs), prev_p));
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      if (c == 0) m_hold = W;
      if (c == d) o_hold = W;
      master_vs = (m_hold > 0);
      out_vs    = (o_hold > 0);
      if (m_hold > 0) m_hold--;
      if (o_hold > 0) o_hold--;
    end
    prev_d  = d;
    prev_p  = p;
    prev_ok = en;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      master_vs = 1'b0;
      out_vs    = 1'b0;
    end
    prev_ok = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // monitor: compare every reported error against the scoreboard
  always @(negedge clk) begin
    if (!rst && err_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected err_valid", int'(err), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(err) == e.e, "R1/R2 error value", int'(err), e.e);
        chk(adj_shorten == e.sh, "R5 adj_shorten", int'(adj_shorten), int'(e.sh));
        chk(adj_lengthen == e.ln, "R5 adj_lengthen", int'(adj_lengthen), int'(e.ln));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(err_valid == 0, "R10 err_valid", int'(err_valid), 0);
    chk(locked == 0, "R10 locked", int'(locked), 0);
    chk(int'(err) == 0, "R10 err", int'(err), 0);
    chk(!adj_shorten && !adj_lengthen, "R10 adjust", int'(adj_shorten | adj_lengthen), 0);
    en = 1'b1;
    @(negedge clk);

    // R1/R6: lock acquisition with offset 0
    drive_frame(40, 0);
    drive_frame(40, 1);
    drive_frame(40, 2);
    drive_frame(40, 39);
    chk(locked == 0, "R6 not yet locked after three", int'(locked), 0);
    drive_frame(40, 5);
    chk(locked == 1, "R6 locked after fourth", int'(locked), 1);
    // R7: single stray frame then recovery
    drive_frame(40, 1);
    chk(locked == 1, "R7 one stray keeps lock", int'(locked), 1);
    drive_frame(40, 0);
    drive_frame(40, 30);
    drive_frame(40, 35);
    chk(locked == 1, "R7 stray run was reset", int'(locked), 1);
    drive_frame(40, 1);
    chk(locked == 0, "R7 two strays drop lock", int'(locked), 0);

    // R2: offsets and wrap points
    track_ofs = 21'd7;
    drive_frame(40, 7);
    drive_frame(40, 0);
    drive_frame(40, 27);
    drive_frame(40, 26);
    track_ofs = 21'd39;
    drive_frame(40, 0);
    track_ofs = 21'd0;
    // R3: period change, even and odd
    drive_frame(40, 20);
    drive_frame(48, 30);
    drive_frame(48, 24);
    drive_frame(48, 23);
    drive_frame(41, 20);
    drive_frame(41, 19);
    track_ofs = 21'd20;
    drive_frame(41, 0);
    track_ofs = 21'd0;

    // relock then R9 enable test
    for (int k = 0; k < 5; k++) drive_frame(40, 0);
    chk(locked == 1, "R6 relocked", int'(locked), 1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(locked == 0, "R9 disable clears lock", int'(locked), 0);
    drive_frame(40, 3);
    drive_frame(40, 3);
    drive_frame(40, 3);
    chk(locked == 0, "R9 stays clear while disabled", int'(locked), 0);
    en = 1'b1;
    drive_frame(40, 2);
    drive_frame(40, 6);
    drive_frame(40, 0);

    // relock then R8 missing master
    for (int k = 0; k < 5; k++) drive_frame(40, 1);
    chk(locked == 1, "R8 locked before loss", int'(locked), 1);
    idle(130);
    chk(locked == 0, "R8 lost master drops lock", int'(locked), 0);
    drive_frame(40, 3);
    drive_frame(40, 10);
    drive_frame(40, 0);
    idle(20);
    chk(q.size() == 0, "R4 all expected results seen", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule